// File: doc/BRIEF.md
# Indexed Load-Store Address Generator

This block computes effective addresses for the memory instructions of a 64-bit integer core that go beyond base-plus-displacement. It handles three operation classes. A register-indexed access adds a scaled second register to the base. An auto-increment access addresses memory at either the base or the stepped base, and hands the stepped base back for writeback. A paired access yields two adjacent element addresses from one small scaled immediate.

Alongside the addresses, the block judges whether the decoded instruction is legal. The checks cover register overlaps that would make the result ambiguous, doubleword forms issued outside 64-bit mode, unsupported pair element sizes and the reserved class code. All results are presented one clock after the request, or in the same cycle when the output register is configured away. The memory interface and the handling of returned data belong elsewhere.

Top module: `agu_idx`

## Requirements
- R1: For class 0 (indexed), with the unsigned-index flag low, addr0 is rs1 + (rs2 << scale), where scale is 0..3 and the sum wraps modulo 2^64.
- R2: For class 0 with the unsigned-index flag high, only rs2 bits [31:0] are used. They are zero-extended to 64 bits and then shifted by scale before the addition.
- R3: For class 1 (increment), the step is the 5-bit immediate, treated as signed (-16..15), sign-extended and multiplied by 2^scale. wb_val is rs1 plus the step, modulo 2^64. wb_en is high only for a legal class 1 request.
- R4: For class 1, addr0 is rs1 plus the step when the pre-increment flag is high, and rs1 unchanged when it is low.
- R5: A class 1 load whose destination register number equals the rs1 register number raises illegal and gives no writeback. A class 1 store with the same numbers is legal.
- R6: For class 2 (pair), with size 3 (doubleword), addr0 is rs1 + pair_imm*16 and addr1 is addr0 + 8. With size 2 (word), addr0 is rs1 + pair_imm*8 and addr1 is addr0 + 4.
- R7: A class 2 load is illegal when rs1 equals either destination or when the two destinations are equal. A class 2 store does no overlap check.
- R8: The following raise illegal:
  - size 3 (doubleword) with mode64 low, in any class;
  - class 2 with size 0 (byte) or 1 (half);
  - class 3 (reserved).
- R9: out_valid follows valid_i one cycle later. When out_valid is low, both illegal and wb_en are low.
- R10: addr1 is zero except for class 2. wb_val is zero except for class 1. Class 3 drives addr0 to zero.
- R11: After reset, out_valid, wb_en, illegal, addr0, addr1 and wb_val are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request present |
| op_cls_i | input | 2 | 0 indexed, 1 increment, 2 pair, 3 reserved |
| is_load_i | input | 1 | Request is a load |
| uoff_i | input | 1 | Use zero-extended low 32 bits of rs2 as index |
| pre_inc_i | input | 1 | Increment form addresses the stepped base |
| mode64_i | input | 1 | Core runs in 64-bit mode |
| size_i | input | 2 | 0 byte, 1 half, 2 word, 3 doubleword |
| scale_i | input | 2 | Shift amount for index or step |
| inc_imm_i | input | 5 | Signed increment immediate |
| pair_imm_i | input | 2 | Pair offset immediate |
| rs1_val_i | input | 64 | Base register value |
| rs2_val_i | input | 64 | Index register value |
| rd_idx_i | input | 5 | First destination or data register number |
| rs1_idx_i | input | 5 | Base register number |
| rd2_idx_i | input | 5 | Second destination register number (pair) |
| out_valid_o | output | 1 | Results valid |
| addr0_o | output | 64 | First effective address |
| addr1_o | output | 64 | Second effective address (pair) |
| wb_en_o | output | 1 | Base writeback enable |
| wb_val_o | output | 64 | Updated base value |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
An increment load carries two results at once: the address computation with base writeback, and the overlap rule that must cancel that writeback. In the sweep over register numbers, destination and base collide in some requests and not in others. For each collision the bench expects the stepped base to still appear on wb_val while wb_en is low and illegal is high. The pair load has the same kind of overlap: while both addresses are produced, the bench checks that any one of the three register collisions flags the request, and that the identical store does not.

// File: rtl/agu_pkg.sv
package agu_pkg;

   typedef enum logic [1:0] {
      CLS_IDX  = 2'd0,
      CLS_INC  = 2'd1,
      CLS_PAIR = 2'd2,
      CLS_RSV  = 2'd3
   } agu_cls_e;

   typedef enum logic [1:0] {
      SZ_B = 2'd0,
      SZ_H = 2'd1,
      SZ_W = 2'd2,
      SZ_D = 2'd3
   } agu_size_e;

endpackage

// File: rtl/agu_index_path.sv
module agu_index_path #(
   parameter int XLEN    = 64,
   parameter int UOFF_W  = 32,
   parameter int SCALE_W = 2
) (
   input  logic [XLEN-1:0]    base_i,
   input  logic [XLEN-1:0]    index_i,
   input  logic [SCALE_W-1:0] scale_i,
   input  logic               uoff_i,
   output logic [XLEN-1:0]    addr_o
);
   localparam int PAD_W = XLEN - UOFF_W;

   if (UOFF_W > XLEN) begin : g_bad_uoff
      $error("agu_index_path: UOFF_W exceeds XLEN");
   end

   logic [XLEN-1:0] narrow_idx;
   logic [XLEN-1:0] chosen_idx;

   if (PAD_W > 0) begin : g_pad
      assign narrow_idx = {{PAD_W{1'b0}}, index_i[UOFF_W-1:0]};
   end else begin : g_nopad
      assign narrow_idx = index_i;
   end

   always_comb begin
      chosen_idx = uoff_i ? narrow_idx : index_i;
      addr_o     = base_i + (chosen_idx << scale_i);
   end
endmodule

// File: rtl/agu_incr_path.sv
module agu_incr_path #(
   parameter int XLEN    = 64,
   parameter int IMM_W   = 5,
   parameter int SCALE_W = 2
) (
   input  logic [XLEN-1:0]    base_i,
   input  logic [IMM_W-1:0]   imm_i,
   input  logic [SCALE_W-1:0] scale_i,
   input  logic               pre_i,
   output logic [XLEN-1:0]    addr_o,
   output logic [XLEN-1:0]    next_base_o
);
   localparam int EXT_W = XLEN - IMM_W;

   if (IMM_W >= XLEN || IMM_W < 2) begin : g_bad_imm
      $error("agu_incr_path: IMM_W out of range");
   end

   logic [XLEN-1:0] step_ext;
   logic [XLEN-1:0] step;

   always_comb begin
      step_ext    = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
      step        = step_ext << scale_i;
      next_base_o = base_i + step;
      addr_o      = pre_i ? next_base_o : base_i;
   end
endmodule

// File: rtl/agu_pair_path.sv
module agu_pair_path #(
   parameter int XLEN   = 64,
   parameter int PIMM_W = 2
) (
   input  logic [XLEN-1:0]   base_i,
   input  logic [PIMM_W-1:0] imm_i,
   input  logic              dword_i,
   output logic [XLEN-1:0]   addr_a_o,
   output logic [XLEN-1:0]   addr_b_o
);
   localparam int N_SIZES = 2;

   if (PIMM_W + 4 > XLEN) begin : g_bad_pimm
      $error("agu_pair_path: PIMM_W too wide for XLEN");
   end

   logic [XLEN-1:0] cand_a [N_SIZES];
   logic [XLEN-1:0] cand_b [N_SIZES];

   for (genvar g = 0; g < N_SIZES; g++) begin : g_elem
      localparam int SH   = 3 + g;
      localparam int ELEM = 4 << g;
      always_comb begin
         cand_a[g] = base_i + (XLEN'(imm_i) << SH);
         cand_b[g] = cand_a[g] + XLEN'(ELEM);
      end
   end

   always_comb begin
      addr_a_o = dword_i ? cand_a[1] : cand_a[0];
      addr_b_o = dword_i ? cand_b[1] : cand_b[0];
   end
endmodule

// File: rtl/agu_legality.sv
module agu_legality
   import agu_pkg::*;
#(
   parameter int REGW = 5
) (
   input  logic [1:0]      cls_i,
   input  logic            is_load_i,
   input  logic [1:0]      size_i,
   input  logic            mode64_i,
   input  logic [REGW-1:0] rd_i,
   input  logic [REGW-1:0] rs1_i,
   input  logic [REGW-1:0] rd2_i,
   output logic            illegal_o
);
   logic dword_bad;
   logic inc_clash;
   logic pair_clash;
   logic pair_size_bad;
   logic rsv;

   always_comb begin
      dword_bad     = (size_i == SZ_D) && !mode64_i;
      inc_clash     = (cls_i == CLS_INC) && is_load_i && (rd_i == rs1_i);
      pair_clash    = (cls_i == CLS_PAIR) && is_load_i &&
                      ((rs1_i == rd_i) || (rs1_i == rd2_i) || (rd_i == rd2_i));
      pair_size_bad = (cls_i == CLS_PAIR) && (size_i != SZ_W) && (size_i != SZ_D);
      rsv           = (cls_i == CLS_RSV);
      illegal_o     = dword_bad | inc_clash | pair_clash | pair_size_bad | rsv;
   end
endmodule

// File: rtl/agu_idx.sv
module agu_idx
   import agu_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int REGW    = 5,
   parameter int IMM_W   = 5,
   parameter int PIMM_W  = 2,
   parameter int SCALE_W = 2,
   parameter int UOFF_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid_i,
   input  logic [1:0]         op_cls_i,
   input  logic               is_load_i,
   input  logic               uoff_i,
   input  logic               pre_inc_i,
   input  logic               mode64_i,
   input  logic [1:0]         size_i,
   input  logic [SCALE_W-1:0] scale_i,
   input  logic [IMM_W-1:0]   inc_imm_i,
   input  logic [PIMM_W-1:0]  pair_imm_i,
   input  logic [XLEN-1:0]    rs1_val_i,
   input  logic [XLEN-1:0]    rs2_val_i,
   input  logic [REGW-1:0]    rd_idx_i,
   input  logic [REGW-1:0]    rs1_idx_i,
   input  logic [REGW-1:0]    rd2_idx_i,
   output logic               out_valid_o,
   output logic [XLEN-1:0]    addr0_o,
   output logic [XLEN-1:0]    addr1_o,
   output logic               wb_en_o,
   output logic [XLEN-1:0]    wb_val_o,
   output logic               illegal_o
);
   if (XLEN != 64) begin : g_bad_xlen
      $error("agu_idx: only a 64-bit datapath is supported");
   end
   if (SCALE_W < 1 || SCALE_W > 3) begin : g_bad_scale
      $error("agu_idx: SCALE_W out of range");
   end

   logic [XLEN-1:0] idx_addr;
   logic [XLEN-1:0] inc_addr;
   logic [XLEN-1:0] inc_next;
   logic [XLEN-1:0] pair_a;
   logic [XLEN-1:0] pair_b;
   logic            ill_raw;

   agu_index_path #(.XLEN(XLEN), .UOFF_W(UOFF_W), .SCALE_W(SCALE_W)) u_index (
      .base_i  (rs1_val_i),
      .index_i (rs2_val_i),
      .scale_i (scale_i),
      .uoff_i  (uoff_i),
      .addr_o  (idx_addr)
   );

   agu_incr_path #(.XLEN(XLEN), .IMM_W(IMM_W), .SCALE_W(SCALE_W)) u_incr (
      .base_i      (rs1_val_i),
      .imm_i       (inc_imm_i),
      .scale_i     (scale_i),
      .pre_i       (pre_inc_i),
      .addr_o      (inc_addr),
      .next_base_o (inc_next)
   );

   agu_pair_path #(.XLEN(XLEN), .PIMM_W(PIMM_W)) u_pair (
      .base_i   (rs1_val_i),
      .imm_i    (pair_imm_i),
      .dword_i  (size_i == SZ_D),
      .addr_a_o (pair_a),
      .addr_b_o (pair_b)
   );

   agu_legality #(.REGW(REGW)) u_legal (
      .cls_i     (op_cls_i),
      .is_load_i (is_load_i),
      .size_i    (size_i),
      .mode64_i  (mode64_i),
      .rd_i      (rd_idx_i),
      .rs1_i     (rs1_idx_i),
      .rd2_i     (rd2_idx_i),
      .illegal_o (ill_raw)
   );

   logic [XLEN-1:0] addr0_d;
   logic [XLEN-1:0] addr1_d;
   logic [XLEN-1:0] wbv_d;
   logic            wbe_d;
   logic            ill_d;

   always_comb begin
      addr0_d = '0;
      addr1_d = '0;
      wbv_d   = '0;
      unique case (agu_cls_e'(op_cls_i))
         CLS_IDX:  addr0_d = idx_addr;
         CLS_INC: begin
            addr0_d = inc_addr;
            wbv_d   = inc_next;
         end
         CLS_PAIR: begin
            addr0_d = pair_a;
            addr1_d = pair_b;
         end
         default:  addr0_d = '0;
      endcase
      ill_d = valid_i & ill_raw;
      wbe_d = valid_i & (op_cls_i == CLS_INC) & ~ill_raw;
   end

   logic [1:0] cls_q;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid_o <= 1'b0;
            addr0_o     <= '0;
            addr1_o     <= '0;
            wb_en_o     <= 1'b0;
            wb_val_o    <= '0;
            illegal_o   <= 1'b0;
            cls_q       <= CLS_IDX;
         end else begin
            out_valid_o <= valid_i;
            addr0_o     <= addr0_d;
            addr1_o     <= addr1_d;
            wb_en_o     <= wbe_d;
            wb_val_o    <= wbv_d;
            illegal_o   <= ill_d;
            cls_q       <= op_cls_i;
         end
      end

      assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
         valid_i |=> out_valid_o);
      assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !valid_i |=> (!out_valid_o && !illegal_o && !wb_en_o));
      assert_inc_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_i && op_cls_i == CLS_INC && is_load_i && rd_idx_i == rs1_idx_i)
         |=> (illegal_o && !wb_en_o));
      assert_post_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_i && op_cls_i == CLS_INC && !pre_inc_i) |=> (addr0_o == $past(rs1_val_i)));
      assert_pair_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_i && op_cls_i == CLS_PAIR && is_load_i && rd_idx_i == rd2_idx_i)
         |=> illegal_o);
      assert_dword_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_i && size_i == SZ_D && !mode64_i) |=> (illegal_o && !wb_en_o));
      assert_pair_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid_o && cls_q == CLS_PAIR && !illegal_o)
         |-> ((addr1_o - addr0_o) == XLEN'(8) || (addr1_o - addr0_o) == XLEN'(4)));
      assert_wb_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
         wb_en_o |-> (out_valid_o && cls_q == CLS_INC && !illegal_o));
   end else begin : g_comb
      always_comb begin
         out_valid_o = valid_i;
         addr0_o     = addr0_d;
         addr1_o     = addr1_d;
         wb_en_o     = wbe_d;
         wb_val_o    = wbv_d;
         illegal_o   = ill_d;
         cls_q       = op_cls_i;
      end
   end
endmodule

// File: tb/tb_agu_idx.sv
`timescale 1ns/100ps
module tb_agu_idx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [1:0]  op_cls_i = '0;
   logic        is_load_i = 1'b0;
   logic        uoff_i = 1'b0;
   logic        pre_inc_i = 1'b0;
   logic        mode64_i = 1'b1;
   logic [1:0]  size_i = '0;
   logic [1:0]  scale_i = '0;
   logic [4:0]  inc_imm_i = '0;
   logic [1:0]  pair_imm_i = '0;
   logic [63:0] rs1_val_i = '0;
   logic [63:0] rs2_val_i = '0;
   logic [4:0]  rd_idx_i = '0;
   logic [4:0]  rs1_idx_i = '0;
   logic [4:0]  rd2_idx_i = '0;
   logic        out_valid_o;
   logic [63:0] addr0_o;
   logic [63:0] addr1_o;
   logic        wb_en_o;
   logic [63:0] wb_val_o;
   logic        illegal_o;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   agu_idx dut (.*);

   task automatic chk(input string tag, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Expected behaviour derived from the requirements alone
   task automatic run_case(input logic [1:0] cls, input bit ld, input bit uo, input bit pre,
                           input bit m64, input logic [1:0] sz, input logic [1:0] sc,
                           input logic [4:0] ii, input logic [1:0] pi,
                           input logic [63:0] b, input logic [63:0] x,
                           input logic [4:0] rd, input logic [4:0] rs, input logic [4:0] rd2,
                           input string tag);
      logic [63:0] e0, e1, ew, off, stepv;
      bit eill, ewe;
      longint signed simm;
      @(negedge clk);
      valid_i = 1'b1; op_cls_i = cls; is_load_i = ld; uoff_i = uo; pre_inc_i = pre;
      mode64_i = m64; size_i = sz; scale_i = sc; inc_imm_i = ii; pair_imm_i = pi;
      rs1_val_i = b; rs2_val_i = x; rd_idx_i = rd; rs1_idx_i = rs; rd2_idx_i = rd2;
      e0 = 0; e1 = 0; ew = 0;
      simm = (ii >= 5'd16) ? longint'(ii) - 32 : longint'(ii);
      stepv = 64'(simm) * (64'd1 << sc);
      case (cls)
         2'd0: begin
            off = uo ? (x & 64'h0000_0000_FFFF_FFFF) : x;
            e0 = b + off * (64'd1 << sc);
         end
         2'd1: begin
            ew = b + stepv;
            e0 = pre ? ew : b;
         end
         2'd2: begin
            e0 = b + 64'(pi) * ((sz == 2'd3) ? 64'd16 : 64'd8);
            e1 = e0 + ((sz == 2'd3) ? 64'd8 : 64'd4);
         end
         default: ;
      endcase
      eill = 1'b0;
      if (sz == 2'd3 && !m64) eill = 1'b1;
      if (cls == 2'd3) eill = 1'b1;
      if (cls == 2'd1 && ld && rd == rs) eill = 1'b1;
      if (cls == 2'd2 && sz < 2'd2) eill = 1'b1;
      if (cls == 2'd2 && ld && (rd == rs || rd2 == rs || rd == rd2)) eill = 1'b1;
      ewe = (cls == 2'd1) && !eill;
      @(negedge clk);
      chk("R9", "out_valid", 64'(out_valid_o), 64'd1);
      chk(tag, "addr0", addr0_o, e0);
      chk((cls == 2'd2) ? tag : "R10", "addr1", addr1_o, e1);
      chk((cls == 2'd1) ? tag : "R10", "wb_val", wb_val_o, ew);
      chk(tag, "wb_en", 64'(wb_en_o), 64'(ewe));
      chk(tag, "illegal", 64'(illegal_o), 64'(eill));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin : stim
      logic [63:0] bases [2];
      logic [63:0] idxs [4];
      bases[0] = 64'h0; bases[1] = 64'hFFFF_FFFF_FFFF_FFF0;
      idxs[0] = 64'hFFFF_FFFF_8000_0001; idxs[1] = 64'h1234_5678_9ABC_DEF0;
      idxs[2] = 64'h0000_0000_FFFF_FFFF; idxs[3] = 64'hFFFF_FFFF_FFFF_FFFF;

      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11", "out_valid", 64'(out_valid_o), 64'd0);
      chk("R11", "addr0", addr0_o, 64'd0);
      chk("R11", "addr1", addr1_o, 64'd0);
      chk("R11", "wb_en", 64'(wb_en_o), 64'd0);
      chk("R11", "wb_val", wb_val_o, 64'd0);
      chk("R11", "illegal", 64'(illegal_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R2 indexed sweep, including wrap-around
      for (int sc = 0; sc < 4; sc++)
         for (int u = 0; u < 2; u++)
            for (int bi = 0; bi < 2; bi++)
               for (int xi = 0; xi < 4; xi++)
                  run_case(2'd0, xi[0], u[0], 1'b0, 1'b1, 2'd3, sc[1:0], 5'd0, 2'd0,
                           bases[bi], idxs[xi], 5'd3, 5'd4, 5'd5, u ? "R2" : "R1");

      // R3 / R4 increment sweep, all immediates and scales
      for (int sc = 0; sc < 4; sc++)
         for (int im = 0; im < 32; im++)
            for (int p = 0; p < 2; p++)
               run_case(2'd1, im[0], 1'b0, p[0], 1'b1, 2'd2, sc[1:0], im[4:0], 2'd0,
                        (im[1] ? 64'h8 : 64'h0000_1000_0000_0000), 64'd0,
                        5'd7, 5'd9, 5'd0, p ? "R4" : "R3");

      // R6 pair addressing
      for (int pi = 0; pi < 4; pi++)
         for (int s = 2; s < 4; s++)
            for (int l = 0; l < 2; l++)
               run_case(2'd2, l[0], 1'b0, 1'b0, 1'b1, s[1:0], 2'd0, 5'd0, pi[1:0],
                        64'hFFFF_FFFF_FFFF_FFE0, 64'd0, 5'd1, 5'd2, 5'd3, "R6");

      // R5 / R7 register overlap sweep
      for (int a = 0; a < 4; a++)
         for (int c = 0; c < 4; c++)
            for (int d = 0; d < 4; d++)
               for (int l = 0; l < 2; l++) begin
                  run_case(2'd2, l[0], 1'b0, 1'b0, 1'b1, 2'd3, 2'd0, 5'd0, 2'd1,
                           64'h4000, 64'd0, a[4:0], c[4:0], d[4:0], "R7");
                  if (d == 0)
                     run_case(2'd1, l[0], 1'b0, 1'b1, 1'b1, 2'd3, 2'd3, 5'd31, 2'd0,
                              64'h4000, 64'd0, a[4:0], c[4:0], 5'd0, "R5");
               end

      // R8 mode, size and reserved-class legality
      for (int cl = 0; cl < 4; cl++)
         for (int s = 0; s < 4; s++)
            for (int m = 0; m < 2; m++)
               run_case(cl[1:0], 1'b0, 1'b0, 1'b1, m[0], s[1:0], 2'd1, 5'd3, 2'd2,
                        64'h100, 64'h10, 5'd1, 5'd2, 5'd3, "R8");

      // R9 idle cycle gives no valid, no flag, no writeback
      @(negedge clk);
      valid_i = 1'b0; op_cls_i = 2'd3;
      @(negedge clk);
      chk("R9", "out_valid idle", 64'(out_valid_o), 64'd0);
      chk("R9", "illegal idle", 64'(illegal_o), 64'd0);
      chk("R9", "wb_en idle", 64'(wb_en_o), 64'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule